// File: doc/BRIEF.md
# PCI Bus-Master Tenure Limiter

This block bounds how long a PCI initiator may keep the bus once it has started a transaction. Configuration software programs an 8-bit slice register through a plain write port. The register's three least significant bits are not stored, so the slice is set in steps of eight PCI clocks. A register value of zero turns the limit off. When the master begins a transaction, the block clears its counter and then counts one step per PCI clock for as long as the master owns the bus.

When the counter reaches the programmed slice, the block raises a sticky expired flag. If the arbiter has withdrawn the grant while that flag is high, the block raises a registered must-terminate request. The master's bus state machine responds by completing its current data phase and releasing the bus. The request is never raised while the grant is still present, however long the slice has been exceeded. The request stays high until the master reports that its final data phase has completed, or until the tenure ends.

Top module: `pci_tenure_limiter`

## Requirements
- R1: While reset is held and in the first cycle after it, the read-back value is 00h and both expired and term_req are low.
- R2: cfg_rd_data always has bits [2:0] at zero. A write stores only bits [7:3], so writing FFh reads back F8h and writing 07h reads back 00h.
- R3: With a nonzero register value V, expired goes high exactly V clock edges after the edge that samples frame_start. A value of 18h gives 24 edges, 08h gives 8 edges and F8h gives 248 edges.
- R4: With the register at 00h, expired and term_req never assert, however long the tenure lasts.
- R5: While gnt is high, term_req does not rise, even after expired has gone high.
- R6: term_req rises on the first edge at which expired is high and gnt is low. Because expired is sticky, a grant withdrawn many cycles after expiry still causes termination on the next edge.
- R7: Once high, term_req stays high until an edge samples phase_done or tenure_end high. It is low after that edge.
- R8: A frame_start pulse clears expired and term_req on its edge and restarts the slice count from zero.
- R9: The count saturates at the slice value: expired stays high for hundreds of cycles past expiry and never wraps back low while the tenure lasts.
- R10: After tenure_end the block stops counting. expired stays low until the next frame_start, however long that takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the slice register |
| cfg_wr_data | input | 8 | Data for the slice register write |
| cfg_rd_data | output | 8 | Current slice register value, bits [2:0] always zero |
| frame_start | input | 1 | One-cycle pulse when the master first drives FRAME# for a new transaction |
| gnt | input | 1 | Bus grant from the arbiter, active high |
| phase_done | input | 1 | Master's final data phase has completed and the bus is released |
| tenure_end | input | 1 | Master has ended its tenure normally |
| expired | output | 1 | Sticky flag: the slice has run out in this tenure |
| term_req | output | 1 | Registered must-terminate request to the master's state machine |

## Verification
The bench builds the block with its default parameters: an 8-bit register whose lowest three bits are reserved. This makes every slice length from 8 to 248 clocks reachable within the run. The bench measures the shortest, a mid-range and the longest slice to the exact edge. It also covers the disabled zero value, the reserved-bit masking on write, and grant withdrawal both before and well after expiry. A restart in mid-tenure and idle time after a tenure has ended are exercised as well.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    localparam int MLT_REG_W_DEF = 8;
    localparam int MLT_RSVD_DEF  = 3;

    typedef enum logic [1:0] {
        TEN_IDLE = 2'd0,
        TEN_OWN  = 2'd1,
        TEN_TERM = 2'd2
    } tenure_e;

    typedef struct packed {
        logic start;
        logic gnt;
        logic phase_done;
        logic tend;
    } bus_evt_t;

    function automatic logic slice_live(input logic any_bits);
        return any_bits;
    endfunction

endpackage

// File: rtl/mlt_cfg_reg.sv
module mlt_cfg_reg #(
    parameter int REG_W = 8,
    parameter int RSVD  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] value
);
    localparam int HI_W = REG_W - RSVD;

    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (wr_en) begin
            hi_q <= wr_data[REG_W-1:RSVD];
        end
    end

    generate
        if (RSVD == 0) begin : g_no_rsvd
            assign value = hi_q;
        end else begin : g_rsvd
            for (genvar b = 0; b < REG_W; b++) begin : g_bit
                if (b < RSVD) begin : g_zero
                    assign value[b] = 1'b0;
                end else begin : g_keep
                    assign value[b] = hi_q[b-RSVD];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mlt_slice_counter.sv
module mlt_slice_counter #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             stop,
    input  logic [REG_W-1:0] limit,
    output logic             expired
);
    logic [REG_W-1:0] cnt_q;
    logic [REG_W-1:0] cnt_nxt;
    logic             exp_q;
    logic             enabled;

    assign enabled = mlt_pkg::slice_live(|limit);

    always_comb begin
        cnt_nxt = cnt_q;
        if (cnt_q < limit) begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (stop) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (run) begin
            cnt_q <= cnt_nxt;
            if (enabled && (cnt_nxt >= limit)) begin
                exp_q <= 1'b1;
            end
        end
    end

    assign expired = exp_q;

endmodule

// File: rtl/mlt_term_ctrl.sv
module mlt_term_ctrl
    import mlt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     expired,
    output logic     run,
    output logic     stop,
    output logic     term_req
);
    tenure_e st_q;
    tenure_e st_nxt;

    always_comb begin
        st_nxt = st_q;
        if (evt.start) begin
            st_nxt = TEN_OWN;
        end else begin
            unique case (st_q)
                TEN_IDLE: st_nxt = TEN_IDLE;
                TEN_OWN: begin
                    if (evt.tend) begin
                        st_nxt = TEN_IDLE;
                    end else if (expired && !evt.gnt) begin
                        st_nxt = TEN_TERM;
                    end
                end
                TEN_TERM: begin
                    if (evt.phase_done || evt.tend) begin
                        st_nxt = TEN_IDLE;
                    end
                end
                default: st_nxt = TEN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= TEN_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    assign run      = (st_q != TEN_IDLE);
    assign stop     = !evt.start && (st_q != TEN_IDLE) && (st_nxt == TEN_IDLE);
    assign term_req = (st_q == TEN_TERM);

endmodule

// File: rtl/pci_tenure_limiter.sv
module pci_tenure_limiter
    import mlt_pkg::*;
#(
    parameter int REG_W = MLT_REG_W_DEF,
    parameter int RSVD  = MLT_RSVD_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             frame_start,
    input  logic             gnt,
    input  logic             phase_done,
    input  logic             tenure_end,
    output logic             expired,
    output logic             term_req
);
    logic [REG_W-1:0] limit;
    logic             run;
    logic             stop;
    bus_evt_t         evt;

    assign evt = '{start: frame_start, gnt: gnt, phase_done: phase_done, tend: tenure_end};

    mlt_cfg_reg #(.REG_W(REG_W), .RSVD(RSVD)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .value   (limit)
    );

    mlt_slice_counter #(.REG_W(REG_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .start   (frame_start),
        .run     (run),
        .stop    (stop),
        .limit   (limit),
        .expired (expired)
    );

    mlt_term_ctrl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .expired  (expired),
        .run      (run),
        .stop     (stop),
        .term_req (term_req)
    );

    assign cfg_rd_data = limit;

endmodule

// File: rtl/mlt_tenure_chk.sv
module mlt_tenure_chk #(
    parameter int REG_W = 8,
    parameter int RSVD  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [REG_W-1:0] cfg_rd_data,
    input logic             frame_start,
    input logic             gnt,
    input logic             phase_done,
    input logic             tenure_end,
    input logic             expired,
    input logic             term_req
);
    localparam logic [REG_W-1:0] LOW_MASK = REG_W'((1 << RSVD) - 1);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!expired && !term_req)); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) (cfg_rd_data & LOW_MASK) == '0); // R2
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data == '0 && !cfg_wr_en && !expired) |=> !expired); // R4
    AST_GNT_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        (gnt && !term_req) |=> !term_req); // R5
    AST_TERM_NEEDS_EXP: assert property (@(posedge clk) disable iff (rst)
        $rose(term_req) |-> $past(expired)); // R6
    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (term_req && !phase_done && !tenure_end && !frame_start) |=> term_req); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!expired && !term_req)); // R8
    AST_EXP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (expired && !frame_start && !tenure_end && !phase_done) |=> expired); // R9

endmodule

bind pci_tenure_limiter mlt_tenure_chk #(.REG_W(REG_W), .RSVD(RSVD)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .frame_start (frame_start),
    .gnt         (gnt),
    .phase_done  (phase_done),
    .tenure_end  (tenure_end),
    .expired     (expired),
    .term_req    (term_req)
);

// File: tb/pci_tenure_limiter_tb.sv
module pci_tenure_limiter_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic       frame_start = 1'b0;
    logic       gnt = 1'b1;
    logic       phase_done = 1'b0;
    logic       tenure_end = 1'b0;
    logic       expired;
    logic       term_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_tenure_limiter u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .frame_start(frame_start), .gnt(gnt),
        .phase_done(phase_done), .tenure_end(tenure_end),
        .expired(expired), .term_req(term_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic begin_tenure();
        frame_start = 1'b1;
        tick(1);
        frame_start = 1'b0;
    endtask

    task automatic finish_tenure();
        tenure_end = 1'b1;
        tick(1);
        tenure_end = 1'b0;
        check(!expired && !term_req, "R7 tenure_end clears", {expired, term_req}, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        check(cfg_rd_data == 8'h00, "R1 reg", cfg_rd_data, 0);
        check(!expired && !term_req, "R1 flags", {expired, term_req}, 0);
        rst = 1'b0;
        tick(1);
        check(!expired && !term_req && cfg_rd_data == 0, "R1 post", {expired, term_req}, 0);
    endtask

    task automatic t_write_mask();
        wr_reg(8'hFF);
        check(cfg_rd_data == 8'hF8, "R2 FF", cfg_rd_data, 8'hF8);
        wr_reg(8'h07);
        check(cfg_rd_data == 8'h00, "R2 07", cfg_rd_data, 0);
        wr_reg(8'h1D);
        check(cfg_rd_data == 8'h18, "R2 1D", cfg_rd_data, 8'h18);
    endtask

    // Slice length with grant held, then a late grant removal (R3, R5, R6, R7).
    task automatic t_slice(input logic [7:0] v, input bit release_by_phase);
        int len = int'(v);
        wr_reg(v);
        gnt = 1'b1;
        begin_tenure();
        tick(len - 1);
        check(expired == 1'b0, "R3 early", expired, 0);
        tick(1);
        check(expired == 1'b1, "R3 at slice", expired, 1);
        tick(12);
        check(term_req == 1'b0, "R5 gnt held", term_req, 0);
        gnt = 1'b0;
        tick(1);
        check(term_req == 1'b1, "R6 late gnt drop", term_req, 1);
        tick(9);
        check(term_req == 1'b1, "R7 held", term_req, 1);
        if (release_by_phase) begin
            phase_done = 1'b1;
            tick(1);
            phase_done = 1'b0;
            check(term_req == 1'b0, "R7 phase_done", term_req, 0);
        end else begin
            finish_tenure();
        end
        gnt = 1'b1;
    endtask

    task automatic t_gnt_low_early();
        wr_reg(8'h10);
        gnt = 1'b0;
        begin_tenure();
        tick(15);
        check(!expired && !term_req, "R6 before", {expired, term_req}, 0);
        tick(1);
        check(expired && !term_req, "R6 expired only", {expired, term_req}, 2);
        tick(1);
        check(term_req == 1'b1, "R6 next edge", term_req, 1);
        finish_tenure();
        gnt = 1'b1;
    endtask

    task automatic t_disabled();
        wr_reg(8'h00);
        gnt = 1'b0;
        begin_tenure();
        tick(400);
        check(!expired && !term_req, "R4 disabled", {expired, term_req}, 0);
        finish_tenure();
        gnt = 1'b1;
    endtask

    task automatic t_saturate();
        wr_reg(8'h08);
        gnt = 1'b1;
        begin_tenure();
        tick(8);
        check(expired == 1'b1, "R3 slice 8", expired, 1);
        tick(300);
        check(expired == 1'b1 && !term_req, "R9 saturate", {expired, term_req}, 2);
        finish_tenure();
    endtask

    task automatic t_restart();
        wr_reg(8'h18);
        gnt = 1'b1;
        begin_tenure();
        tick(30);
        check(expired == 1'b1, "R8 first expiry", expired, 1);
        begin_tenure();
        check(!expired && !term_req, "R8 cleared", {expired, term_req}, 0);
        tick(23);
        check(expired == 1'b0, "R8 recount early", expired, 0);
        tick(1);
        check(expired == 1'b1, "R8 recount", expired, 1);
        finish_tenure();
    endtask

    task automatic t_idle_after_end();
        wr_reg(8'h08);
        gnt = 1'b0;
        begin_tenure();
        tick(3);
        finish_tenure();
        tick(40);
        check(!expired && !term_req, "R10 idle", {expired, term_req}, 0);
        gnt = 1'b1;
    endtask

    initial begin
        t_reset();
        t_write_mask();
        t_slice(8'h18, 1'b1);
        t_slice(8'hF8, 1'b0);
        t_gnt_low_early();
        t_disabled();
        t_saturate();
        t_restart();
        t_idle_after_end();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule